// File: doc/BRIEF.md
# Hot Swap Power Sequencing Controller

This block is the digital mode sequencer behind a hot swap power switch. It decides when the external pass transistor's gate may be driven, when the gate must be discharged, and when the supply-sensing divider is connected for a sample. Analog parts are outside it and reach it as flags: the comparators, the charge pump, the current limiting loop and the fault timing capacitor. All timing counts a one-millisecond `tick` enable, so delays are set by tick counts.

A start always passes through a debounce interval before the gate ramps. The supply is sampled only in a short window that recurs periodically. The undervoltage result comes from a turn-on input while the gate is off and from a turn-off input while it is on, which gives the thresholds hysteresis. A status output is released once the gate is first seen high and is cleared again by any fault or by disabling. After an overcurrent lasts long enough to trip the fault timer, the block either stays latched off until enable or lockout is cycled, or restarts by itself after a retry delay. A parameter chooses between these two behaviours.

Top module: `hs_ctrl`

## Requirements
- R1: `mode` is one-hot, with bit 0 shutdown, bit 1 debounce, bit 2 startup, bit 3 on, bit 4 voltage fault, bit 5 overcurrent and bit 6 current fault. Reset gives shutdown.
- R2: While `enable` is high and `lockout` low (active), `div_strobe` is a one-cycle pulse once every STROBE_TICKS ticks. It never pulses while inactive.
- R3: Debounce is entered on the edge after the block becomes active from shutdown, or after enable or lockout was cycled. Startup follows after DEBOUNCE_TICKS ticks spent in debounce.
- R4: `gate_en` is high only while active in startup, on or overcurrent. `gate_dis` is its complement.
- R5: `status_rel` goes high on the edge after `gate_hi` is seen in startup, and stays high through on and overcurrent.
- R6: `status_rel` is cleared on the edge after any of these: becoming inactive, a sample violation, or entry into current fault.
- R7: A sample violation is `ov_flag | (gate driven ? uv_off_flag : uv_on_flag)`, taken in a strobe cycle. From debounce, startup, on or overcurrent it leads to voltage fault.
- R8: Voltage fault returns to debounce after a strobe cycle that shows no violation.
- R9: `oc_flag` in startup or on leads to overcurrent. There `timer_chg` follows `oc_flag`. When `oc_flag` drops, the block returns to on if status is released and to startup otherwise.
- R10: `timer_hit` in overcurrent leads to current fault. This takes priority over a violation sampled in the same cycle.
- R11: With AUTO_RETRY=0, current fault persists until enable or lockout is cycled. With AUTO_RETRY=1, it moves to debounce after RETRY_TICKS ticks.
- R12: In on mode, `pump_refresh` pulses in the same cycle as `gate_droop`, and otherwise REFRESH_TICKS ticks after the previous refresh or after entry to on mode.
- R13: While inactive, `gate_dis` is high and `timer_chg` low. The state moves to shutdown only once `gate_low` is seen, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-millisecond time base enable |
| enable | input | 1 | Switch enable request |
| lockout | input | 1 | Supply below lockout level |
| ov_flag | input | 1 | Overvoltage comparator result |
| uv_on_flag | input | 1 | Undervoltage result, turn-on threshold |
| uv_off_flag | input | 1 | Undervoltage result, turn-off threshold |
| gate_hi | input | 1 | Gate has reached its high level |
| gate_droop | input | 1 | Gate has drooped below refresh level |
| gate_low | input | 1 | Gate is below its low threshold |
| oc_flag | input | 1 | Circuit breaker comparator tripped |
| timer_hit | input | 1 | Fault timer reached threshold |
| gate_en | output | 1 | Gate pull-up enable |
| gate_dis | output | 1 | Gate discharge request |
| div_strobe | output | 1 | Connect sensing divider (sample window) |
| pump_refresh | output | 1 | Charge pump refresh request |
| status_rel | output | 1 | Status released (1) or pulled low (0) |
| timer_chg | output | 1 | Fault timer charge enable |
| mode | output | 7 | One-hot mode code |

## Verification
Two events can land in the same cycle: a sample window that reports a supply violation, and a fault-timer trip while in overcurrent. The bench holds the overcurrent flag and polls for the strobe cycle. In that cycle it raises both the overvoltage flag and `timer_hit`, then expects current fault on the next edge rather than voltage fault. In the same way, a gate droop is placed near a periodic refresh, and the bench expects a single refresh pulse followed by a full refresh interval that restarts from the droop.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        ST_SHUT  = 3'd0,
        ST_DEB   = 3'd1,
        ST_START = 3'd2,
        ST_ON    = 3'd3,
        ST_VFLT  = 3'd4,
        ST_OCUR  = 3'd5,
        ST_CFLT  = 3'd6
    } hs_state_e;

    localparam int MODE_W = 7;

    typedef struct packed {
        logic ov;
        logic uv_on;
        logic uv_off;
    } hs_sample_t;

    function automatic logic [MODE_W-1:0] mode_code(hs_state_e s);
        logic [MODE_W-1:0] one;
        one = {{(MODE_W-1){1'b0}}, 1'b1};
        return one << s;
    endfunction

    function automatic logic gate_driven(hs_state_e s);
        return (s == ST_START) || (s == ST_ON) || (s == ST_OCUR);
    endfunction

    function automatic logic sample_bad(hs_sample_t smp, logic gate_up);
        return smp.ov | (gate_up ? smp.uv_off : smp.uv_on);
    endfunction

endpackage

// File: rtl/hs_tick_cnt.sv
module hs_tick_cnt #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign done = tick && !clr && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= done ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/hs_seq.sv
module hs_seq
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      strobe,
    input  logic      viol,
    input  logic      gate_hi,
    input  logic      oc,
    input  logic      timer_hit,
    input  logic      gate_low,
    input  logic      deb_done,
    input  logic      retry_done,
    output hs_state_e state,
    output logic      status,
    output logic      rearm
);
    hs_state_e nxt;
    logic      bad;

    assign bad = strobe && viol;

    always_comb begin
        nxt = state;
        if (!active) begin
            if (gate_low)
                nxt = ST_SHUT;
        end else if (rearm || state == ST_SHUT) begin
            nxt = ST_DEB;
        end else begin
            case (state)
                ST_DEB:   if (bad) nxt = ST_VFLT;
                          else if (deb_done) nxt = ST_START;
                ST_START: if (bad) nxt = ST_VFLT;
                          else if (oc) nxt = ST_OCUR;
                          else if (gate_hi) nxt = ST_ON;
                ST_ON:    if (bad) nxt = ST_VFLT;
                          else if (oc) nxt = ST_OCUR;
                ST_OCUR:  if (timer_hit) nxt = ST_CFLT;
                          else if (bad) nxt = ST_VFLT;
                          else if (!oc) nxt = status ? ST_ON : ST_START;
                ST_VFLT:  if (strobe && !viol) nxt = ST_DEB;
                ST_CFLT:  if (retry_done) nxt = ST_DEB;
                default:  nxt = ST_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_SHUT;
            status <= 1'b0;
            rearm  <= 1'b0;
        end else begin
            state <= nxt;
            rearm <= !active;
            if (!active || nxt == ST_VFLT || nxt == ST_CFLT)
                status <= 1'b0;
            else if (state == ST_START && gate_hi && !bad)
                status <= 1'b1;
        end
    end
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
    import hs_pkg::*;
#(
    parameter int DEBOUNCE_TICKS = 40,
    parameter int STROBE_TICKS   = 10,
    parameter int REFRESH_TICKS  = 15,
    parameter int RETRY_TICKS    = 500,
    parameter bit AUTO_RETRY     = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              enable,
    input  logic              lockout,
    input  logic              ov_flag,
    input  logic              uv_on_flag,
    input  logic              uv_off_flag,
    input  logic              gate_hi,
    input  logic              gate_droop,
    input  logic              gate_low,
    input  logic              oc_flag,
    input  logic              timer_hit,
    output logic              gate_en,
    output logic              gate_dis,
    output logic              div_strobe,
    output logic              pump_refresh,
    output logic              status_rel,
    output logic              timer_chg,
    output logic [MODE_W-1:0] mode
);
    hs_state_e  state;
    hs_sample_t smp;
    logic       active, rearm, viol;
    logic       deb_done, retry_done, ref_done;
    logic       in_on;

    assign active = enable && !lockout;
    assign smp    = '{ov: ov_flag, uv_on: uv_on_flag, uv_off: uv_off_flag};
    assign viol   = sample_bad(smp, gate_driven(state));
    assign in_on  = active && (state == ST_ON);

    hs_tick_cnt #(.LIMIT(STROBE_TICKS)) u_strobe (
        .clk(clk), .rst(rst), .clr(!active), .tick(tick), .done(div_strobe)
    );

    hs_tick_cnt #(.LIMIT(DEBOUNCE_TICKS)) u_deb (
        .clk(clk), .rst(rst), .clr(!active || rearm || state != ST_DEB),
        .tick(tick), .done(deb_done)
    );

    hs_tick_cnt #(.LIMIT(REFRESH_TICKS)) u_ref (
        .clk(clk), .rst(rst), .clr(!in_on || gate_droop),
        .tick(tick), .done(ref_done)
    );

    generate
        if (AUTO_RETRY) begin : g_retry
            hs_tick_cnt #(.LIMIT(RETRY_TICKS)) u_retry (
                .clk(clk), .rst(rst), .clr(!active || state != ST_CFLT),
                .tick(tick), .done(retry_done)
            );
        end else begin : g_latch
            assign retry_done = 1'b0;
        end
    endgenerate

    hs_seq u_seq (
        .clk(clk), .rst(rst), .active(active), .strobe(div_strobe),
        .viol(viol), .gate_hi(gate_hi), .oc(oc_flag), .timer_hit(timer_hit),
        .gate_low(gate_low), .deb_done(deb_done), .retry_done(retry_done),
        .state(state), .status(status_rel), .rearm(rearm)
    );

    assign gate_en      = active && gate_driven(state);
    assign gate_dis     = !gate_en;
    assign timer_chg    = active && (state == ST_OCUR) && oc_flag;
    assign pump_refresh = in_on && (gate_droop || ref_done);
    assign mode         = mode_code(state);
endmodule

// File: rtl/hs_ctrl_chk.sv
module hs_ctrl_chk
    import hs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              lockout,
    input logic              gate_hi,
    input logic              oc_flag,
    input logic              timer_hit,
    input logic              gate_en,
    input logic              gate_dis,
    input logic              div_strobe,
    input logic              pump_refresh,
    input logic              status_rel,
    input logic              timer_chg,
    input logic [MODE_W-1:0] mode
);
    logic act;
    assign act = enable && !lockout;

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(mode) == 1); // R1
    AST_STROBE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        div_strobe |-> act); // R2
    AST_GATE_MODE: assert property (@(posedge clk) disable iff (rst)
        gate_en |-> (mode[ST_START] || mode[ST_ON] || mode[ST_OCUR])); // R4
    AST_STATUS_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(status_rel) |-> ($past(gate_hi) && $past(mode[ST_START]))); // R5
    AST_STATUS_FAULT: assert property (@(posedge clk) disable iff (rst)
        (mode[ST_VFLT] || mode[ST_CFLT]) |-> !status_rel); // R6
    AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(!act) |-> !status_rel); // R6
    AST_TIMER_OC: assert property (@(posedge clk) disable iff (rst)
        timer_chg |-> (mode[ST_OCUR] && oc_flag)); // R9
    AST_CF_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(mode[ST_CFLT]) |-> ($past(timer_hit) && $past(mode[ST_OCUR]))); // R10
    AST_REFRESH_ON: assert property (@(posedge clk) disable iff (rst)
        pump_refresh |-> mode[ST_ON]); // R12
    AST_IDLE_DISCHARGE: assert property (@(posedge clk) disable iff (rst)
        !act |-> (gate_dis && !gate_en && !timer_chg)); // R13
endmodule

bind hs_ctrl hs_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .enable(enable), .lockout(lockout),
    .gate_hi(gate_hi), .oc_flag(oc_flag), .timer_hit(timer_hit),
    .gate_en(gate_en), .gate_dis(gate_dis), .div_strobe(div_strobe),
    .pump_refresh(pump_refresh), .status_rel(status_rel),
    .timer_chg(timer_chg), .mode(mode)
);

// File: tb/sim_hs_ctrl.sv
module sim_hs_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] M_SHUT = 7'd1, M_DEB = 7'd2, M_START = 7'd4,
                           M_ON = 7'd8, M_VF = 7'd16, M_OC = 7'd32, M_CF = 7'd64;

    logic clk = 0, rst = 1, tick = 1, en = 0, lockout = 0;
    logic ov = 0, uv_on = 0, uv_off = 0, gate_hi = 0, droop = 0, gate_low = 0;
    logic oc = 0, timer_hit = 0;
    logic g0, d0, s0, r0, st0, t0, g1, d1, s1, r1, st1, t1;
    logic [6:0] m0, m1;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_ctrl #(.AUTO_RETRY(1'b0)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .enable(en), .lockout(lockout),
        .ov_flag(ov), .uv_on_flag(uv_on), .uv_off_flag(uv_off), .gate_hi(gate_hi),
        .gate_droop(droop), .gate_low(gate_low), .oc_flag(oc), .timer_hit(timer_hit),
        .gate_en(g0), .gate_dis(d0), .div_strobe(s0), .pump_refresh(r0),
        .status_rel(st0), .timer_chg(t0), .mode(m0));

    hs_ctrl #(.AUTO_RETRY(1'b1)) u1 (
        .clk(clk), .rst(rst), .tick(tick), .enable(en), .lockout(lockout),
        .ov_flag(ov), .uv_on_flag(uv_on), .uv_off_flag(uv_off), .gate_hi(gate_hi),
        .gate_droop(droop), .gate_low(gate_low), .oc_flag(oc), .timer_hit(timer_hit),
        .gate_en(g1), .gate_dis(d1), .div_strobe(s1), .pump_refresh(r1),
        .status_rel(st1), .timer_chg(t1), .mode(m1));

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tk();
        @(posedge clk); #1;
    endtask

    task automatic wait_strobe();
        for (int g = 0; g < 50 && !s0; g++) tk();
    endtask

    task automatic go_on();
        gate_hi = 1;
        for (int g = 0; g < 300 && m0 != M_ON; g++) tk();
    endtask

    task automatic recycle();
        en = 0; tk(); en = 1; tk();
    endtask

    initial begin
        int c;
        repeat (3) tk();
        rst = 0; #1;
        // R1 R13: reset state
        chk("R1 reset mode", m0, M_SHUT);
        chk("R13 reset discharge", d0, 1);
        chk("R4 reset gate", g0, 0);
        chk("R6 reset status", st0, 0);
        chk("R2 no strobe idle", s0, 0);

        en = 1; tk();
        chk("R3 enter debounce", m0, M_DEB);
        c = 0;
        while (m0 == M_DEB && c < 200) begin tk(); c++; end
        chk("R3 debounce length", c, 40);
        chk("R3 startup", m0, M_START);
        chk("R4 gate on in startup", g0, 1);
        chk("R5 status held low", st0, 0);
        gate_hi = 1; tk();
        chk("R5 enter on", m0, M_ON);
        chk("R5 status released", st0, 1);

        // R2 strobe period
        wait_strobe(); tk(); c = 1;
        while (!s0 && c < 50) begin tk(); c++; end
        chk("R2 strobe period", c, 10);

        // R12 refresh
        for (int g = 0; g < 40 && !r0; g++) tk();
        tk(); c = 1;
        while (!r0 && c < 50) begin tk(); c++; end
        chk("R12 refresh period", c, 15);
        tk(); tk(); droop = 1; #1;
        chk("R12 droop refresh", r0, 1);
        tk(); droop = 0; #1; c = 1;
        while (!r0 && c < 50) begin tk(); c++; end
        chk("R12 refresh after droop", c, 15);

        // R9 overcurrent from on
        oc = 1; tk();
        chk("R9 enter overcurrent", m0, M_OC);
        chk("R9 timer charge", t0, 1);
        oc = 0; #1;
        chk("R9 timer charge off", t0, 0);
        tk();
        chk("R9 back to on", m0, M_ON);

        // R7 R8 sweep: gate low (debounce) and gate high (on)
        for (int gh = 0; gh < 2; gh++) begin
            for (int v = 0; v < 8; v++) begin
                bit exp;
                if (gh == 1) go_on(); else recycle();
                wait_strobe();
                ov = v[2]; uv_on = v[1]; uv_off = v[0];
                exp = v[2] | (gh == 1 ? v[0] : v[1]);
                tk();
                chk($sformatf("R7 sweep gh=%0d v=%0d", gh, v), m0,
                    exp ? M_VF : (gh == 1 ? M_ON : M_DEB));
                if (gh == 1) begin
                    chk("R6 status after sample", st0, exp ? 0 : 1);
                    chk("R4 gate after sample", g0, exp ? 0 : 1);
                end
                ov = 0; uv_on = 0; uv_off = 0;
                if (exp) begin
                    wait_strobe(); tk();
                    chk("R8 recover to debounce", m0, M_DEB);
                end
            end
        end

        // R9 overcurrent from startup returns to startup
        gate_hi = 0; recycle();
        for (int g = 0; g < 100 && m0 != M_START; g++) tk();
        oc = 1; tk();
        chk("R9 oc from startup", m0, M_OC);
        oc = 0; tk();
        chk("R9 back to startup", m0, M_START);

        // R10 coincidence of violation and timer trip
        go_on();
        oc = 1; tk();
        wait_strobe();
        ov = 1; timer_hit = 1; tk();
        chk("R10 latch wins", m0, M_CF);
        chk("R10 latch wins retry unit", m1, M_CF);
        chk("R6 status cleared on latch", st0, 0);
        ov = 0; timer_hit = 0; oc = 0; #1;
        chk("R13 no charge in latch", t0, 0);
        chk("R4 gate off in latch", g0, 0);
        c = 0;
        while (m1 == M_CF && c < 1000) begin tk(); c++; end
        chk("R11 retry delay", c, 500);
        chk("R11 retry to debounce", m1, M_DEB);
        chk("R11 latch-off holds", m0, M_CF);
        repeat (100) tk();
        chk("R11 latch-off still holds", m0, M_CF);

        // R13 disable: discharge until gate low
        en = 0; #1;
        chk("R13 discharge while disabled", d0, 1);
        tk();
        chk("R13 hold until gate low", m0, M_CF);
        gate_low = 1; tk();
        chk("R13 shutdown on gate low", m0, M_SHUT);
        gate_low = 0; en = 1; tk();
        chk("R11 release by enable cycle", m0, M_DEB);

        // lockout
        go_on();
        lockout = 1; #1;
        chk("R4 gate off on lockout", g0, 0);
        tk();
        chk("R6 status cleared on lockout", st0, 0);
        c = 0;
        for (int g = 0; g < 30; g++) begin tk(); if (s0) c++; end
        chk("R2 no strobe in lockout", c, 0);
        lockout = 0; tk();
        chk("R3 debounce after lockout", m0, M_DEB);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule